// File: doc/BRIEF.md
# LCD panel scan timing generator

This block drives a passive matrix LCD panel. It counts shift periods within a line and lines within a frame. It reads display bytes through a one-cycle-latency memory read port and sends them to the panel 4 or 8 bits at a time, paired with a shift clock. At the end of each line it produces the line latch pulse. It also drives the first-line marker and the AC-inversion signal, and passes a panel enable bit through.

A single-screen panel is supported in two forms: 8-bit, with one beat per byte, and 4-bit, with two beats per byte. A dual-scan panel is also supported. In dual-scan mode every line reads a byte from the upper half of the image and a byte from the lower half, and the two halves share the 8-bit bus one nibble each. The configuration inputs are sampled continuously and are expected to stay static while the block runs.

The sequencer is a state machine with five states:
- IDLE: the reset state. It loads the frame pointers and moves to PRIME.
- PRIME: four cycles that fetch the first byte group of a line. It moves to SHIFT.
- SHIFT: sends beats. It moves to LATCH after the last group of the line.
- LATCH: holds the line latch pulse high. It moves to ADV when the width count expires.
- ADV: one cycle in which the line counter advances, wrapping at the end of the frame. It moves back to PRIME.

Top module: `lcd_scan_timer`

## Requirements
- R1: While `rst_n` is low, `sclk`, `lpulse`, `flm`, `acinv`, `vd`, `mem_rd` and `panel_en` are all 0. The first `sclk` high appears after the fifth rising clock edge that follows reset release.
- R2: A shift period lasts two clock cycles, with `sclk` high in the first and low in the second. `vd` changes only in cycles where `sclk` rises, so it is stable across each falling edge of `sclk`.
- R3: Single-screen 8-bit mode (`cfg_dual`=0, `cfg_wide`=1) sends one beat per byte with `vd` equal to the byte. Column c of line l is read from address l*N+c, where N is the byte count.
- R4: Single-screen 4-bit mode (`cfg_dual`=0, `cfg_wide`=0) sends two beats per byte. The beats carry bits 7:4 and then bits 3:0, both on `vd[3:0]`, and `vd[7:4]` is 0.
- R5: Dual-scan mode (`cfg_dual`=1) scans H = floor(`cfg_lines`/2) lines per frame and ignores `cfg_wide`. Column c of line l pairs the upper byte U at l*N+c with the lower byte W at (H+l)*N+c. The first beat is {U[7:4],W[7:4]} and the second is {U[3:0],W[3:0]}.
- R6: `lpulse` rises once the last beat of a line has been sent. It stays high for 2*max(1,`cfg_lp_width`) cycles, and `sclk` stays low throughout.
- R7: `flm` is high during the whole first line of a frame, including its latch pulse, and does not change in the cycle where `lpulse` falls. The row driver therefore sees it high at the fall that ends line 0 and low at every other fall.
- R8: `acinv` toggles in the cycle after the `lpulse` fall that ends the last line of a frame, and at no other time. The read addresses restart at the start of every frame.
- R9: There is one read per byte: N reads per line in single mode and 2N in dual mode. Each read is issued while the previous byte group is being sent, and `mem_rdata` is taken in the cycle after `mem_rd`.
- R10: `panel_en` follows `cfg_panel_on` one clock later.
- R11: A `cfg_bytes` value of 0 is treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bytes | input | BYTES_W | Bytes per line (per half in dual-scan) |
| cfg_lines | input | LINES_W | Panel rows |
| cfg_wide | input | 1 | 1: 8-bit single-screen output, 0: 4-bit |
| cfg_dual | input | 1 | Dual-scan enable |
| cfg_lp_width | input | LPW_W | Latch pulse width in shift periods (0 acts as 1) |
| cfg_panel_on | input | 1 | Panel enable request |
| mem_rd | output | 1 | Read strobe to the display memory |
| mem_addr | output | ADDR_W | Read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| vd | output | 8 | Display data bus |
| sclk | output | 1 | Shift clock |
| lpulse | output | 1 | Line latch pulse |
| flm | output | 1 | First-line marker |
| acinv | output | 1 | AC-inversion signal |
| panel_en | output | 1 | Registered panel enable |

## Verification
After reset release, the first `sclk` high is due after five rising edges. The bench counts those edges one at a time and samples each one at the following falling edge. `panel_en` is due one edge after `cfg_panel_on` changes, and is checked at the falling edge after that one edge. A monitor samples every output at falling clock edges only, so each latch width is counted in whole cycles and beat values are taken while `sclk` is high. `flm`, `acinv` and the read count are recorded in the cycle where `lpulse` is first seen low, which is before the `acinv` toggle and before the next line's first read.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRIME,
        ST_SHIFT,
        ST_LATCH,
        ST_ADV
    } scan_state_e;
endpackage

// File: rtl/lcd_beat_mux.sv
module lcd_beat_mux #(
    parameter int NIB = 4
) (
    input  logic [2*NIB-1:0] up_byte,
    input  logic [2*NIB-1:0] lo_byte,
    input  logic             beat,
    input  logic             wide,
    input  logic             dual,
    input  logic             en,
    output logic [2*NIB-1:0] vd
);
    localparam int LANES = 2;

    logic [NIB-1:0] up_nib;
    logic [NIB-1:0] lo_nib;

    // beat 0 carries the high nibble, beat 1 the low nibble
    assign up_nib = beat ? up_byte[NIB-1:0] : up_byte[2*NIB-1:NIB];
    assign lo_nib = beat ? lo_byte[NIB-1:0] : lo_byte[2*NIB-1:NIB];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [NIB-1:0] lane_v;
        always_comb begin
            if (!en) begin
                lane_v = '0;
            end else if (dual) begin
                lane_v = (g == LANES - 1) ? up_nib : lo_nib;
            end else if (wide) begin
                lane_v = up_byte[g*NIB +: NIB];
            end else begin
                lane_v = (g == 0) ? up_nib : '0;
            end
        end
        assign vd[g*NIB +: NIB] = lane_v;
    end
endmodule

// File: rtl/lcd_fetch_addr.sv
module lcd_fetch_addr #(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] half_base,
    input  logic              step_up,
    input  logic              step_lo,
    output logic [ADDR_W-1:0] up_ptr,
    output logic [ADDR_W-1:0] lo_ptr
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            up_ptr <= '0;
            lo_ptr <= '0;
        end else if (load) begin
            up_ptr <= '0;
            lo_ptr <= half_base;
        end else begin
            if (step_up) up_ptr <= up_ptr + ADDR_W'(1);
            if (step_lo) lo_ptr <= lo_ptr + ADDR_W'(1);
        end
    end
endmodule

// File: rtl/lcd_line_ctr.sv
module lcd_line_ctr #(
    parameter int LINES_W = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               advance,
    input  logic [LINES_W-1:0] scan_last,
    output logic [LINES_W-1:0] line,
    output logic               at_last,
    output logic               ac
);
    assign at_last = (line == scan_last);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line <= '0;
            ac   <= 1'b0;
        end else if (clear) begin
            line <= '0;
        end else if (advance) begin
            if (at_last) begin
                line <= '0;
                ac   <= ~ac;
            end else begin
                line <= line + LINES_W'(1);
            end
        end
    end

    // R8: frame wrap returns to line 0 and flips the inversion signal
    assert_ac_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !clear && at_last) |=> (line == '0 && ac != $past(ac)));
endmodule

// File: rtl/lcd_scan_timer.sv
module lcd_scan_timer
    import lcd_scan_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int BYTES_W = 8,
    parameter int LINES_W = 10,
    parameter int LPW_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BYTES_W-1:0] cfg_bytes,
    input  logic [LINES_W-1:0] cfg_lines,
    input  logic               cfg_wide,
    input  logic               cfg_dual,
    input  logic [LPW_W-1:0]   cfg_lp_width,
    input  logic               cfg_panel_on,
    output logic               mem_rd,
    output logic [ADDR_W-1:0]  mem_addr,
    input  logic [7:0]         mem_rdata,
    output logic [7:0]         vd,
    output logic               sclk,
    output logic               lpulse,
    output logic               flm,
    output logic               acinv,
    output logic               panel_en
);
    localparam int DW     = 8;
    localparam int NIB    = DW / 2;
    localparam int LCNT_W = LPW_W + 1;

    scan_state_e state, state_nx;

    logic [1:0]         ph;
    logic [1:0]         ph_last;
    logic [BYTES_W-1:0] grp;
    logic [BYTES_W-1:0] n_last;
    logic [LCNT_W-1:0]  lcnt;
    logic [LCNT_W-1:0]  lp_last;
    logic [LPW_W-1:0]   w_eff;
    logic [DW-1:0]      cur_up, cur_lo, nxt_up, nxt_lo;
    logic               up_pend, lo_pend;
    logic               grp_long, more_grps;
    logic               fetch_up, fetch_lo;
    logic               frame_load, line_adv, at_last, ac_q;
    logic [LINES_W-1:0] scan_cnt, scan_last, line;
    logic [ADDR_W-1:0]  half_base, up_ptr, lo_ptr;
    logic               shift_en;
    logic [DW-1:0]      vd_w;

    // ---------------- configuration decode ----------------
    always_comb begin
        n_last    = (cfg_bytes == '0) ? '0 : cfg_bytes - BYTES_W'(1);
        grp_long  = cfg_dual | ~cfg_wide;
        ph_last   = grp_long ? 2'd3 : 2'd1;
        w_eff     = (cfg_lp_width == '0) ? LPW_W'(1) : cfg_lp_width;
        lp_last   = {w_eff, 1'b0} - LCNT_W'(1);
        scan_cnt  = cfg_dual ? (cfg_lines >> 1) : cfg_lines;
        scan_last = (scan_cnt == '0) ? '0 : scan_cnt - LINES_W'(1);
        half_base = ADDR_W'(cfg_lines >> 1) * (ADDR_W'(n_last) + ADDR_W'(1));
    end

    assign more_grps = (grp != n_last);

    // ---------------- next state ----------------
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  state_nx = ST_PRIME;
            ST_PRIME: if (ph == 2'd3) state_nx = ST_SHIFT;
            ST_SHIFT: if (ph == ph_last && !more_grps) state_nx = ST_LATCH;
            ST_LATCH: if (lcnt == lp_last) state_nx = ST_ADV;
            ST_ADV:   state_nx = ST_PRIME;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // ---------------- fetch requests ----------------
    // The next group is requested at the start of the current one
    always_comb begin
        fetch_up = (state == ST_PRIME && ph == 2'd0) ||
                   (state == ST_SHIFT && ph == 2'd0 && more_grps);
        fetch_lo = cfg_dual &&
                   ((state == ST_PRIME && ph == 2'd1) ||
                    (state == ST_SHIFT && ph == 2'd1 && more_grps));
    end

    assign mem_rd   = fetch_up | fetch_lo;
    assign mem_addr = fetch_lo ? lo_ptr : up_ptr;

    // ---------------- datapath ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph       <= '0;
            grp      <= '0;
            lcnt     <= '0;
            cur_up   <= '0;
            cur_lo   <= '0;
            nxt_up   <= '0;
            nxt_lo   <= '0;
            up_pend  <= 1'b0;
            lo_pend  <= 1'b0;
            panel_en <= 1'b0;
        end else begin
            up_pend  <= fetch_up;
            lo_pend  <= fetch_lo;
            panel_en <= cfg_panel_on;
            if (up_pend) nxt_up <= mem_rdata;
            if (lo_pend) nxt_lo <= mem_rdata;
            unique case (state)
                ST_IDLE: begin
                    ph  <= '0;
                    grp <= '0;
                end
                ST_PRIME: begin
                    ph <= ph + 2'd1;
                    if (ph == 2'd3) begin
                        cur_up <= nxt_up;
                        cur_lo <= nxt_lo;
                        grp    <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (ph == ph_last) begin
                        ph <= '0;
                        if (more_grps) begin
                            grp    <= grp + BYTES_W'(1);
                            // short groups take the returning byte directly
                            cur_up <= grp_long ? nxt_up : mem_rdata;
                            cur_lo <= nxt_lo;
                        end else begin
                            lcnt <= '0;
                        end
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                ST_LATCH: lcnt <= lcnt + LCNT_W'(1);
                ST_ADV:   ph   <= '0;
                default:  ph   <= '0;
            endcase
        end
    end

    assign frame_load = (state == ST_IDLE) || (state == ST_ADV && at_last);
    assign line_adv   = (state == ST_ADV);

    lcd_fetch_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (frame_load),
        .half_base (half_base),
        .step_up   (fetch_up),
        .step_lo   (fetch_lo),
        .up_ptr    (up_ptr),
        .lo_ptr    (lo_ptr)
    );

    lcd_line_ctr #(.LINES_W(LINES_W)) u_line (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (state == ST_IDLE),
        .advance   (line_adv),
        .scan_last (scan_last),
        .line      (line),
        .at_last   (at_last),
        .ac        (ac_q)
    );

    lcd_beat_mux #(.NIB(NIB)) u_mux (
        .up_byte (cur_up),
        .lo_byte (cur_lo),
        .beat    (ph[1]),
        .wide    (cfg_wide),
        .dual    (cfg_dual),
        .en      (shift_en),
        .vd      (vd_w)
    );

    // ---------------- outputs ----------------
    always_comb begin
        shift_en = (state == ST_SHIFT);
        sclk     = (state == ST_SHIFT) && !ph[0];
        lpulse   = (state == ST_LATCH);
        flm      = (state != ST_IDLE) && (line == '0);
        acinv    = ac_q;
        vd       = vd_w;
    end

    // ---------------- assertions ----------------
    // R2: data holds across every shift clock fall
    assert_vd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sclk) |-> $stable(vd));
    // R6: shift clock is quiet under the latch pulse
    assert_sclk_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        lpulse |-> !sclk);
    // R6: latch pulse lasts at least two cycles
    assert_lp_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lpulse) |=> lpulse);
    // R7: marker is steady where the row driver samples it
    assert_flm_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lpulse) |-> $stable(flm));
endmodule

// File: tb/sim_lcd_scan_timer.sv
`timescale 1ns/1ps
module sim_lcd_scan_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_bytes = 8'd2;
    logic [9:0]  cfg_lines = 10'd2;
    logic        cfg_wide = 1'b1;
    logic        cfg_dual = 1'b0;
    logic [3:0]  cfg_lp_width = 4'd1;
    logic        cfg_panel_on = 1'b0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'd0;
    logic [7:0]  vd;
    logic        sclk, lpulse, flm, acinv, panel_en;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    always #2 clk = ~clk;

    lcd_scan_timer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bytes(cfg_bytes), .cfg_lines(cfg_lines),
        .cfg_wide(cfg_wide), .cfg_dual(cfg_dual), .cfg_lp_width(cfg_lp_width),
        .cfg_panel_on(cfg_panel_on), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .vd(vd), .sclk(sclk), .lpulse(lpulse), .flm(flm),
        .acinv(acinv), .panel_en(panel_en)
    );

    function automatic logic [7:0] fbyte(input int a);
        int t;
        t = a * 29 + 7 + (a >> 8);
        return t[7:0];
    endfunction

    // memory model: one-cycle read latency
    always @(posedge clk) if (mem_rd) mem_rdata <= fbyte(int'(mem_addr));

    // monitor, sampling at falling clock edges
    logic [7:0] beat_log [0:511];
    int  lp_len [0:63];
    bit  flm_log [0:63];
    bit  ac_log [0:63];
    int  rd_at_fall [0:63];
    int  beat_n, lp_n, rd_n, cur_lp, vd_chg, sclk_long, lp_sclk;
    bit  prev_sclk, prev_lp;
    logic [7:0] vd_hi;

    always @(negedge clk) begin
        if (!rst_n) begin
            beat_n = 0; lp_n = 0; rd_n = 0; cur_lp = 0;
            vd_chg = 0; sclk_long = 0; lp_sclk = 0;
            prev_sclk = 0; prev_lp = 0; vd_hi = 0;
        end else begin
            if (mem_rd) rd_n++;
            if (sclk && prev_sclk) sclk_long++;
            if (prev_sclk && !sclk) begin
                if (vd != vd_hi) vd_chg++;
                if (beat_n < 512) beat_log[beat_n] = vd_hi;
                beat_n++;
            end
            if (sclk) vd_hi = vd;
            if (lpulse) cur_lp++;
            if (lpulse && sclk) lp_sclk++;
            if (prev_lp && !lpulse) begin
                if (lp_n < 64) begin
                    lp_len[lp_n] = cur_lp;
                    flm_log[lp_n] = flm;
                    ac_log[lp_n] = acinv;
                    rd_at_fall[lp_n] = rd_n;
                end
                lp_n++;
                cur_lp = 0;
            end
            prev_sclk = sclk;
            prev_lp = lpulse;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below %0d", cyc, 150000);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    // reset state, start latency, panel enable
    task automatic t_reset_and_enable();
        int k;
        @(negedge clk);
        rst_n = 0; cfg_wide = 1; cfg_dual = 0; cfg_bytes = 2; cfg_lines = 2;
        cfg_lp_width = 1; cfg_panel_on = 1;
        repeat (3) @(negedge clk);
        check(sclk == 0 && lpulse == 0 && flm == 0 && acinv == 0, "R1 ctl low", int'({sclk, lpulse, flm, acinv}), 0);
        check(vd == 0 && mem_rd == 0, "R1 data low", int'(vd) + int'(mem_rd), 0);
        check(panel_en == 0, "R10 held in reset", int'(panel_en), 0);
        rst_n = 1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
            if (k == 1) check(flm == 1, "R7 flm on first line", int'(flm), 1);
        end while (!sclk && k < 20);
        check(k == 5, "R1 first sclk edge count", k, 5);
        check(panel_en == 1, "R10 enable follows", int'(panel_en), 1);
        cfg_panel_on = 0;
        @(negedge clk);
        check(panel_en == 0, "R10 disable follows", int'(panel_en), 0);
    endtask

    // run two frames and check the whole output stream
    task automatic run_case(input string tag, input bit wide, input bit dual,
                            input int nb, input int nl, input int w);
        int neff, L, bpl, rpl, idx, guard, exp_lp, hb, au, al;
        logic [7:0] u, lo, e0, e1;
        neff = (nb == 0) ? 1 : nb;
        L = dual ? nl / 2 : nl;
        bpl = (dual || !wide) ? 2 * neff : neff;
        rpl = dual ? 2 * neff : neff;
        exp_lp = 2 * ((w == 0) ? 1 : w);
        hb = nl / 2;
        @(negedge clk);
        rst_n = 0; cfg_wide = wide; cfg_dual = dual; cfg_bytes = 8'(nb);
        cfg_lines = 10'(nl); cfg_lp_width = 4'(w);
        repeat (3) @(negedge clk);
        rst_n = 1;
        guard = 0;
        while (lp_n < 2 * L && guard < 20000) begin
            @(posedge clk);
            guard++;
        end
        @(negedge clk);
        check(lp_n >= 2 * L, {tag, " line count"}, lp_n, 2 * L);
        check(beat_n == 2 * L * bpl, {tag, " beat total"}, beat_n, 2 * L * bpl);
        idx = 0;
        for (int f = 0; f < 2; f++) begin
            for (int l = 0; l < L; l++) begin
                for (int c = 0; c < neff; c++) begin
                    au = l * neff + c;
                    al = (hb + l) * neff + c;
                    u  = fbyte(au);
                    lo = fbyte(al);
                    if (dual) begin
                        e0 = {u[7:4], lo[7:4]}; e1 = {u[3:0], lo[3:0]};
                    end else begin
                        e0 = {4'h0, u[7:4]}; e1 = {4'h0, u[3:0]};
                    end
                    if (!dual && wide) begin
                        check(idx < 512 && beat_log[idx] == u, {tag, " byte beat"}, int'(beat_log[idx]), int'(u));
                        idx++;
                    end else begin
                        check(idx < 511 && beat_log[idx] == e0, {tag, " beat 0"}, int'(beat_log[idx]), int'(e0));
                        check(idx < 511 && beat_log[idx + 1] == e1, {tag, " beat 1"}, int'(beat_log[idx + 1]), int'(e1));
                        idx += 2;
                    end
                end
            end
        end
        check(vd_chg == 0 && sclk_long == 0, "R2 shift period shape", vd_chg + sclk_long, 0);
        check(lp_sclk == 0, "R6 sclk low in latch", lp_sclk, 0);
        for (int i = 0; i < 2 * L; i++) begin
            check(lp_len[i] == exp_lp, "R6 latch width", lp_len[i], exp_lp);
            check(flm_log[i] == ((i % L) == 0), "R7 flm at latch fall", int'(flm_log[i]), int'((i % L) == 0));
        end
        check(ac_log[L] != ac_log[L - 1], "R8 ac toggles at wrap", int'(ac_log[L]), int'(!ac_log[L - 1]));
        check(ac_log[L - 1] == ac_log[0] && ac_log[2 * L - 1] == ac_log[L], "R8 ac steady in frame",
              int'(ac_log[L - 1]), int'(ac_log[0]));
        check(rd_at_fall[2 * L - 1] == 2 * L * rpl, "R9 read count", rd_at_fall[2 * L - 1], 2 * L * rpl);
    endtask

    task automatic t_single_wide();   run_case("R3", 1, 0, 3, 3, 1); endtask
    task automatic t_single_narrow(); run_case("R4", 0, 0, 4, 3, 2); endtask
    task automatic t_dual();
        run_case("R5", 1, 1, 3, 6, 1);
        run_case("R5 narrow flag", 0, 1, 2, 4, 2);
    endtask
    task automatic t_latch_width();
        run_case("R6 zero width", 1, 0, 2, 2, 0);
        run_case("R6 wide pulse", 1, 0, 2, 2, 3);
    endtask
    task automatic t_zero_bytes();    run_case("R11", 1, 0, 0, 2, 1); endtask

    initial begin
        t_reset_and_enable();
        t_single_wide();
        t_single_narrow();
        t_dual();
        t_latch_width();
        t_zero_bytes();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule